// File: doc/BRIEF.md
# Double-Buffered Quadrature Carrier Oscillator

This block is a numerically controlled oscillator. It produces signed cosine and sine samples that a downconversion mixer uses to shift a carrier to baseband. On each enabled sample clock, a 32-bit phase accumulator advances by the active tuning word. The accumulator output plus a phase offset is cut down to a 24-bit phase. The top bits of that phase address a quarter-wave amplitude table. Quadrant folding then rebuilds the full-circle cosine and sine.

A host interface writes four addresses. Address 0 is a tuning-word staging register. Address 1 is the phase offset. Address 2 holds control bits. Address 3 is a commit strobe. A new tuning word waits in the staging register and does not affect the running frequency until it is committed. A commit comes from the host strobe, or from an external alignment pulse when that path is enabled. A commit can also restart the accumulator at zero, so that several oscillators can be phase-aligned by one shared pulse. The phase offset has no staging register and applies from the next sample.

Top module: `carrier_nco`

## Requirements
- R1: A synchronous reset (`rst` high) clears the staging word, the active word, the offset, the control bits and the accumulator. While reset is held and after it is released, `valid_o` is 0 and `cos_o`, `sin_o` and `phase_o` are 0. The first sample after reset has phase 0.
- R2: A host write to address 0 loads only the staging register. The output phase progression keeps using the previously active word until a commit occurs.
- R3: A host write to address 3, with any data, is a commit: the active word takes the staging value, and the first step taken after that edge uses the new word.
- R4: `sync_in` high at a clock edge is a commit only when control bit 0 (written at address 2) is 1. When that bit is 0, `sync_in` has no effect on the outputs.
- R5: When control bit 1 is set, a commit edge sets the accumulator to zero, whatever `en` is. The sample captured at the next enabled edge then has phase equal to the offset alone.
- R6: At each edge with `en` high and no zeroing commit, the accumulator gains the active word modulo 2^32. With `en` low, it holds its value.
- R7: A host write to address 1 sets the phase offset with no staging. Every sample captured at a later edge uses the accumulator plus the new offset, modulo 2^32.
- R8: `phase_o` equals the top 24 bits of (accumulator + offset), as sampled at the enabled edge two clocks before `valid_o`.
- R9: With k equal to the top 10 bits of that sum, `cos_o` equals round(262143·cos(2π(k+0.5)/1024)) and `sin_o` equals round(262143·sin(2π(k+0.5)/1024)). Here k bits 9:8 select the quadrant and sign, and rounding goes half away from zero.
- R10: `valid_o` equals `en` delayed by exactly two clock edges. While `valid_o` is 0, `cos_o`, `sin_o` and `phase_o` keep their last values.
- R11: A valid output never carries the most negative 19-bit code (-262144). Both axes are symmetric about zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; one accumulator step and one output sample |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | 0 staging word, 1 phase offset, 2 control {bit1 zero-on-commit, bit0 sync enable}, 3 commit |
| wr_data | input | 32 | Host write data |
| sync_in | input | 1 | External alignment pulse |
| cos_o | output | 19 | Signed cosine sample |
| sin_o | output | 19 | Signed sine sample |
| phase_o | output | 24 | Truncated phase of the current sample |
| valid_o | output | 1 | Sample valid, two clocks after `en` |

## Verification
The embedded properties take for granted that host writes are single-cycle strobes. They also assume that a commit and a write to the staging register in the same cycle follow the rule that the commit moves the previous staging value. The stimulus keeps `sync_in` to one-cycle pulses. It changes `en`, the offset and the control bits only between edges, and it holds `en` low around a mid-run reset, so every sample is tied to a single accumulator state. A bench model of the registers and the two-edge pipeline predicts every sample. This allows full sweeps across all 1024 table positions and checks of offset wrap-around near 2^32.

// File: rtl/carrier_nco.sv
module carrier_nco #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 24,
  parameter int AMP_W   = 19,
  parameter int TBL_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [FREQ_W-1:0]        wr_data,
  input  logic                     sync_in,
  output logic signed [AMP_W-1:0]  cos_o,
  output logic signed [AMP_W-1:0]  sin_o,
  output logic [PHASE_W-1:0]       phase_o,
  output logic                     valid_o
);

  localparam int TBL_N = 1 << TBL_W;
  localparam int AMAX  = (1 << (AMP_W-1)) - 1;
  localparam int SHIFT = FREQ_W - PHASE_W;
  localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  typedef logic [AMP_W-2:0] qtab_t [TBL_N];

  function automatic qtab_t build_tab();
    qtab_t t;
    real   ang;
    for (int i = 0; i < TBL_N; i++) begin
      ang  = (real'(i) + 0.5) * 3.14159265358979323846 / (2.0 * real'(TBL_N));
      t[i] = (AMP_W-1)'($rtoi($sin(ang) * real'(AMAX) + 0.5));
    end
    return t;
  endfunction

  localparam qtab_t QTAB = build_tab();

  logic [FREQ_W-1:0]  hold_q, freq_q, offs_q, acc_q;
  logic               sync_en_q, zero_ld_q;
  logic [PHASE_W-1:0] ph_r;
  logic               v1;

  logic hit_hold, hit_offs, hit_ctl, hit_xfer, commit;
  assign hit_hold = wr_en && (wr_addr == 2'd0);
  assign hit_offs = wr_en && (wr_addr == 2'd1);
  assign hit_ctl  = wr_en && (wr_addr == 2'd2);
  assign hit_xfer = wr_en && (wr_addr == 2'd3);
  assign commit   = hit_xfer || (sync_in && sync_en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      freq_q    <= '0;
      offs_q    <= '0;
      acc_q     <= '0;
      sync_en_q <= 1'b0;
      zero_ld_q <= 1'b0;
    end else begin
      if (hit_hold) hold_q <= wr_data;
      if (hit_offs) offs_q <= wr_data;
      if (hit_ctl) {zero_ld_q, sync_en_q} <= wr_data[1:0];
      if (commit) freq_q <= hold_q;
      if (commit && zero_ld_q) acc_q <= '0;
      else if (en)             acc_q <= acc_q + freq_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_r <= '0;
      v1   <= 1'b0;
    end else begin
      v1 <= en;
      if (en) ph_r <= PHASE_W'((acc_q + offs_q) >> SHIFT);
    end
  end

  logic [1:0]       quad;
  logic [TBL_W-1:0] idx;
  logic [AMP_W-2:0] mag_a, mag_b, sin_mag, cos_mag;
  logic signed [AMP_W-1:0] sin_v, cos_v;

  assign quad    = ph_r[PHASE_W-1 -: 2];
  assign idx     = ph_r[PHASE_W-3 -: TBL_W];
  assign mag_a   = QTAB[idx];
  assign mag_b   = QTAB[~idx];
  assign sin_mag = quad[0] ? mag_b : mag_a;
  assign cos_mag = quad[0] ? mag_a : mag_b;
  assign sin_v   = quad[1]           ? AMP_W'(-{1'b0, sin_mag}) : {1'b0, sin_mag};
  assign cos_v   = (quad[1]^quad[0]) ? AMP_W'(-{1'b0, cos_mag}) : {1'b0, cos_mag};

  always_ff @(posedge clk) begin
    if (rst) begin
      cos_o   <= '0;
      sin_o   <= '0;
      phase_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= v1;
      if (v1) begin
        cos_o   <= cos_v;
        sin_o   <= sin_v;
        phase_o <= ph_r;
      end
    end
  end

  // R2
  hold_only_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_hold && !commit) |=> $stable(freq_q));

  // R3
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (freq_q == $past(hold_q)));

  // R5
  zero_ld_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && zero_ld_q) |=> (acc_q == '0));

  // R6
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !commit) |=> ((acc_q - $past(acc_q)) == $past(freq_q)));

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !commit) |=> $stable(acc_q));

  // R7
  offs_chk: assert property (@(posedge clk) disable iff (rst)
    hit_offs |=> (offs_q == $past(wr_data)));

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> ##1 valid_o);

  // R10
  valid_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ##1 !valid_o);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> ($stable(cos_o) && $stable(sin_o) && $stable(phase_o)));

  // R11
  no_min_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((cos_o != MOST_NEG) && (sin_o != MOST_NEG)));

endmodule

// File: tb/sim_carrier_nco.sv
`timescale 1ns/1ps
module sim_carrier_nco;
  localparam int    TW   = 8;
  localparam int    QB   = TW + 2;
  localparam int    AMAX = 262143;
  localparam real   PI   = 3.14159265358979323846;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, wr_en = 1'b0, sync_in = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic signed [18:0] cos_o, sin_o;
  logic [23:0] phase_o;
  logic valid_o;

  carrier_nco u0 (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .cos_o(cos_o), .sin_o(sin_o),
    .phase_o(phase_o), .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;

  int    checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  logic [31:0] hold_m, freq_m, offs_m, acc_m;
  logic        sen_m, zld_m, en_d1, en_d2;
  logic [31:0] exp_q[$];
  logic signed [18:0] last_cos, last_sin;
  logic [23:0] last_ph;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int ref_amp(input logic [31:0] p, input bit want_sin);
    int  k;
    real a, x;
    k = int'(p >> (32 - QB));
    a = 2.0 * PI * (real'(k) + 0.5) / real'(1 << QB);
    x = real'(AMAX) * (want_sin ? $sin(a) : $cos(a));
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      hold_m = '0; freq_m = '0; offs_m = '0; acc_m = '0;
      sen_m = 1'b0; zld_m = 1'b0; en_d1 = 1'b0; en_d2 = 1'b0;
      exp_q.delete();
    end else begin
      bit cm;
      cm = (wr_en && wr_addr == 2'd3) || (sync_in && sen_m);
      if (en) exp_q.push_back(acc_m + offs_m);
      en_d2 = en_d1;
      en_d1 = en;
      if (cm && zld_m) acc_m = '0;
      else if (en)     acc_m = acc_m + freq_m;
      if (cm) freq_m = hold_m;
      if (wr_en && wr_addr == 2'd0) hold_m = wr_data;
      if (wr_en && wr_addr == 2'd1) offs_m = wr_data;
      if (wr_en && wr_addr == 2'd2) {zld_m, sen_m} = wr_data[1:0];
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      last_cos = '0; last_sin = '0; last_ph = '0;
    end else begin
      chk(valid_o == en_d2, "R10", "valid timing", valid_o, en_d2);
      if (valid_o) begin
        logic [31:0] p;
        int ec, es;
        p = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
        ec = ref_amp(p, 1'b0);
        es = ref_amp(p, 1'b1);
        chk(phase_o == p[31:8], {cur_req, " R8"}, "phase", phase_o, p[31:8]);
        chk(int'(cos_o) == ec, {cur_req, " R9"}, "cos", cos_o, ec);
        chk(int'(sin_o) == es, {cur_req, " R9"}, "sin", sin_o, es);
        chk(cos_o != -19'sd262144 && sin_o != -19'sd262144, "R11",
            "most negative code", cos_o, -262143);
      end else begin
        chk(cos_o == last_cos && sin_o == last_sin && phase_o == last_ph,
            "R10", "hold while invalid", cos_o, last_cos);
      end
      last_cos = cos_o; last_sin = sin_o; last_ph = phase_o;
    end
  end

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = (mode == 0) ? 1'b1 : (mode == 1) ? (i % 3 != 2) : 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(valid_o == 1'b0 && cos_o == 0 && sin_o == 0 && phase_o == 0,
        "R1", "reset outputs", {valid_o, cos_o}, 0);

    cur_req = "R1";
    run(3, 0);
    en = 1'b0;
    run(3, 2);

    cur_req = "R8/R9";
    host_write(2'd0, 32'h0040_0000);
    host_write(2'd3, 32'h0);
    run(1030, 0);

    cur_req = "R2";
    host_write(2'd0, 32'h9E37_79B9);
    run(60, 0);

    cur_req = "R4";
    pulse_sync();
    run(20, 0);
    host_write(2'd2, 32'h1);
    pulse_sync();
    run(200, 0);

    cur_req = "R3";
    host_write(2'd0, 32'h00C0_0000);
    run(10, 0);
    host_write(2'd3, 32'hFFFF_FFFF);
    run(100, 0);

    cur_req = "R7";
    foreach (offs_list[i]) begin
      host_write(2'd1, offs_list[i]);
      run(30, 0);
    end

    cur_req = "R5";
    host_write(2'd2, 32'h2);
    host_write(2'd0, 32'h0123_4567);
    run(20, 0);
    host_write(2'd3, 32'h0);
    run(50, 0);
    host_write(2'd2, 32'h3);
    run(7, 2);
    pulse_sync();
    run(50, 0);
    host_write(2'd2, 32'h0);

    cur_req = "R6";
    host_write(2'd1, 32'h0);
    host_write(2'd0, 32'h1234_5678);
    host_write(2'd3, 32'h0);
    run(300, 1);

    cur_req = "R10";
    run(12, 2);
    run(60, 1);
    run(5, 2);

    cur_req = "R1";
    rst = 1'b1;
    run(3, 2);
    rst = 1'b0;
    @(negedge clk);
    // R1: mid-run reset clears registers and outputs
    chk(valid_o == 1'b0 && cos_o == 0 && sin_o == 0 && phase_o == 0,
        "R1", "outputs after second reset", {valid_o, cos_o}, 0);
    run(50, 0);
    run(4, 2);
    finish_run();
  end

  logic [31:0] offs_list [8] = '{32'h0000_0000, 32'h4000_0000, 32'hFFFF_FFFF,
                                 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                                 32'hC03F_FFFF, 32'h2468_ACE0};
endmodule